// File: doc/BRIEF.md
# Scalar Issue Group Packer

The block accepts a stream of four-channel vector instructions. It breaks each instruction into independent single-channel scalar operations, one for each channel enabled in the instruction's write mask. It then packs those operations, in program order, into issue groups of up to five slots. Each channel operation reads the same channel of its three source registers and writes that channel of its destination register. An operation joins the open group only if it is independent of everything already in the group. Otherwise the open group is sent out and the operation starts a new one.

Instructions arrive on a valid/ready interface. Completed groups leave on a second valid/ready interface through a one-deep output register. Each group carries a slot-valid vector and, for every slot, the opcode, the channel number and the register indices. An input flagged as last marks the end of a run. It forces the open group out, so that no operation after it shares a group with an operation before it.

Top module: `vliw_group_packer`

## Requirements
- R1: An instruction with k bits set in its 4-bit write mask (bit c enables channel c) produces exactly k scalar operations. Each operation carries the instruction's opcode, destination and three source indices, plus its channel number c on slot_ch.
- R2: A channel whose mask bit is clear produces no operation. An instruction with an all-zero mask adds nothing to any group.
- R3: A group holds at most five operations. The operation that fills the fifth slot sends the group out.
- R4: Every emitted group has slot 0 valid, and its valid slots are contiguous from slot 0 upward (slot_vld has the form 2^n-1).
- R5: An operation that reads register r on channel c, where (r, c) is written by an operation already in the open group, closes that group and becomes slot 0 of the next group.
- R6: An operation that writes a register-channel pair already written in the open group closes that group and becomes slot 0 of the next group.
- R7: Operations appear in input instruction order, and within one instruction in ascending channel order. Slot i holds the (i+1)-th operation of its group.
- R8: After the operations of an instruction flagged last, the open group is sent out even if it is not full. No group is sent while the run is still open and nothing forces a close.
- R9: in_ready_o is low while an accepted instruction still has channel operations waiting to be packed.
- R10: While grp_valid_o is high and grp_ready_i is low, the output group and its slot fields hold unchanged.
- R11: The active-low asynchronous reset empties the open group, discards pending channel operations, deasserts grp_valid_o and leaves in_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Instruction accepted when high with valid |
| in_last_i | input | 1 | Instruction ends the run; close the group after it |
| in_op_i | input | OP_W | Opcode |
| in_dst_i | input | REG_W | Destination register index |
| in_src0_i | input | REG_W | First source register index |
| in_src1_i | input | REG_W | Second source register index |
| in_src2_i | input | REG_W | Third source register index |
| in_mask_i | input | 4 | Channel write mask, bit c enables channel c |
| grp_valid_o | output | 1 | Issue group valid |
| grp_ready_i | input | 1 | Downstream takes the group |
| slot_vld_o | output | SLOTS | Per-slot valid, slot 0 in bit 0 |
| slot_op_o | output | SLOTS*OP_W | Opcode per slot |
| slot_ch_o | output | SLOTS*2 | Channel number per slot |
| slot_dst_o | output | SLOTS*REG_W | Destination index per slot |
| slot_src0_o | output | SLOTS*REG_W | First source index per slot |
| slot_src1_o | output | SLOTS*REG_W | Second source index per slot |
| slot_src2_o | output | SLOTS*REG_W | Third source index per slot |

## Verification
The assertions check on every cycle that emitted groups are non-empty and packed from slot 0, and that no slot reads or rewrites a register channel written by an earlier slot of the same group. They also check that a stalled group holds still, that the input stalls while a multi-channel instruction is being split, and that reset leaves the block idle. The bench scenarios are needed for the rest: where each group boundary falls and which operations land in each slot, in what order. This covers mask expansion, zero masks, closes on full, closes on conflict and closes on last, with and without backpressure, and a reset that discards a half-built group.

// File: rtl/vliw_pack_pkg.sv
package vliw_pack_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CH_W    = 2;
  localparam int unsigned NUM_SRC = 3;

  // open-group action chosen each cycle
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_APPEND,
    ACT_SPLIT,   // emit old group, op starts new one
    ACT_FILL,    // emit group with op in last slot
    ACT_FLUSH    // emit old group, leave empty
  } act_e;
endpackage

// File: rtl/vliw_chan_split.sv
module vliw_chan_split
  import vliw_pack_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned REG_W = 2,
  parameter int unsigned OPB   = OP_W + CH_W + 4 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_last_i,
  input  logic [OP_W-1:0]   in_op_i,
  input  logic [REG_W-1:0]  in_dst_i,
  input  logic [REG_W-1:0]  in_src0_i,
  input  logic [REG_W-1:0]  in_src1_i,
  input  logic [REG_W-1:0]  in_src2_i,
  input  logic [NUM_CH-1:0] in_mask_i,
  output logic              op_valid_o,
  output logic [OPB-1:0]    op_o,
  output logic              close_req_o,
  input  logic              op_take_i,
  input  logic              close_done_i
);
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  dst_q, src0_q, src1_q, src2_q;
  logic [NUM_CH-1:0] rem_q;
  logic              last_q;
  logic [NUM_CH-1:0] pick_oh;
  logic [CH_W-1:0]   pick_idx;
  logic              found;

  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    found    = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rem_q[c] && !found) begin
        pick_oh[c] = 1'b1;
        pick_idx   = CH_W'(c);
        found      = 1'b1;
      end
    end
  end

  assign op_valid_o  = |rem_q;
  assign close_req_o = last_q && (rem_q == '0);
  assign in_ready_o  = (rem_q == '0) && !last_q;
  assign op_o        = {op_q, pick_idx, dst_q, src0_q, src1_q, src2_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      dst_q  <= '0;
      src0_q <= '0;
      src1_q <= '0;
      src2_q <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      op_q   <= in_op_i;
      dst_q  <= in_dst_i;
      src0_q <= in_src0_i;
      src1_q <= in_src1_i;
      src2_q <= in_src2_i;
      rem_q  <= in_mask_i;
      last_q <= in_last_i;
    end else begin
      if (op_take_i)    rem_q  <= rem_q & ~pick_oh;
      if (close_done_i) last_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vliw_dep_check.sv
module vliw_dep_check
  import vliw_pack_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned REG_W = 2,
  parameter int unsigned OPB   = OP_W + CH_W + 4 * REG_W,
  parameter int unsigned IDX_W = REG_W + CH_W,
  parameter int unsigned NPAIR = 1 << IDX_W
) (
  input  logic [NPAIR-1:0] wr_set_i,
  input  logic [OPB-1:0]   op_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             conflict_o
);
  logic [CH_W-1:0]    ch;
  logic [REG_W-1:0]   dst;
  logic [NUM_SRC-1:0] rd_hit;

  assign ch       = op_i[4*REG_W +: CH_W];
  assign dst      = op_i[3*REG_W +: REG_W];
  assign wr_idx_o = {dst, ch};

  // sources sit below dst: src0 at 2*REG_W, src2 at 0
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic [REG_W-1:0] src;
    assign src       = op_i[(NUM_SRC-1-k)*REG_W +: REG_W];
    assign rd_hit[k] = wr_set_i[{src, ch}];
  end

  assign conflict_o = (|rd_hit) || wr_set_i[wr_idx_o];
endmodule

// File: rtl/vliw_open_group.sv
module vliw_open_group
  import vliw_pack_pkg::*;
#(
  parameter int unsigned SLOTS = 5,
  parameter int unsigned OPB   = 14,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned NPAIR = 1 << IDX_W,
  parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  act_e               act_i,
  input  logic [OPB-1:0]     op_i,
  input  logic [IDX_W-1:0]   op_idx_i,
  output logic [SLOTS*OPB-1:0] cur_data_o,
  output logic [SLOTS-1:0]   cur_vld_o,
  output logic [SLOTS*OPB-1:0] fill_data_o,
  output logic [SLOTS-1:0]   fill_vld_o,
  output logic [NPAIR-1:0]   wr_set_o,
  output logic               empty_o,
  output logic               last_slot_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NPAIR-1:0] wr_q;
  logic [NPAIR-1:0] idx_oh;

  assign idx_oh      = NPAIR'(1) << op_idx_i;
  assign wr_set_o    = wr_q;
  assign empty_o     = (cnt_q == '0);
  assign last_slot_o = (cnt_q == CNT_W'(SLOTS - 1));

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [OPB-1:0] slot_q;
    assign cur_data_o[i*OPB +: OPB]  = slot_q;
    assign cur_vld_o[i]              = (CNT_W'(i) < cnt_q);
    assign fill_data_o[i*OPB +: OPB] = (cnt_q == CNT_W'(i)) ? op_i : slot_q;
    assign fill_vld_o[i]             = (CNT_W'(i) <= cnt_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else begin
        case (act_i)
          ACT_APPEND: if (cnt_q == CNT_W'(i)) slot_q <= op_i;
          ACT_SPLIT:  slot_q <= (i == 0) ? op_i : '0;
          ACT_FILL,
          ACT_FLUSH:  slot_q <= '0;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      wr_q  <= '0;
    end else begin
      case (act_i)
        ACT_APPEND: begin
          cnt_q <= cnt_q + 1'b1;
          wr_q  <= wr_q | idx_oh;
        end
        ACT_SPLIT: begin
          cnt_q <= CNT_W'(1);
          wr_q  <= idx_oh;
        end
        ACT_FILL, ACT_FLUSH: begin
          cnt_q <= '0;
          wr_q  <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vliw_group_out.sv
module vliw_group_out #(
  parameter int unsigned SLOTS = 5,
  parameter int unsigned OPB   = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [SLOTS*OPB-1:0] data_i,
  input  logic [SLOTS-1:0]     vld_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic [SLOTS*OPB-1:0] data_o,
  output logic [SLOTS-1:0]     vld_o,
  output logic                 free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      vld_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      vld_o   <= vld_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vliw_group_packer.sv
module vliw_group_packer
  import vliw_pack_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned REG_W = 2,
  parameter int unsigned SLOTS = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic                   in_last_i,
  input  logic [OP_W-1:0]        in_op_i,
  input  logic [REG_W-1:0]       in_dst_i,
  input  logic [REG_W-1:0]       in_src0_i,
  input  logic [REG_W-1:0]       in_src1_i,
  input  logic [REG_W-1:0]       in_src2_i,
  input  logic [3:0]             in_mask_i,
  output logic                   grp_valid_o,
  input  logic                   grp_ready_i,
  output logic [SLOTS-1:0]       slot_vld_o,
  output logic [SLOTS*OP_W-1:0]  slot_op_o,
  output logic [SLOTS*2-1:0]     slot_ch_o,
  output logic [SLOTS*REG_W-1:0] slot_dst_o,
  output logic [SLOTS*REG_W-1:0] slot_src0_o,
  output logic [SLOTS*REG_W-1:0] slot_src1_o,
  output logic [SLOTS*REG_W-1:0] slot_src2_o
);
  localparam int unsigned OPB   = OP_W + CH_W + 4 * REG_W;
  localparam int unsigned IDX_W = REG_W + CH_W;
  localparam int unsigned NPAIR = 1 << IDX_W;

  logic             op_valid, close_req, op_take, close_done;
  logic [OPB-1:0]   op;
  logic [IDX_W-1:0] op_idx;
  logic             conflict;
  logic [NPAIR-1:0] wr_set;
  logic             grp_empty, last_slot, out_free;
  logic             emit, emit_fill;
  act_e             act;
  logic [SLOTS*OPB-1:0] cur_data, fill_data, emit_data, out_data;
  logic [SLOTS-1:0]     cur_vld, fill_vld, emit_vld;

  vliw_chan_split #(.OP_W(OP_W), .REG_W(REG_W), .OPB(OPB)) u_split (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .in_last_i    (in_last_i),
    .in_op_i      (in_op_i),
    .in_dst_i     (in_dst_i),
    .in_src0_i    (in_src0_i),
    .in_src1_i    (in_src1_i),
    .in_src2_i    (in_src2_i),
    .in_mask_i    (in_mask_i),
    .op_valid_o   (op_valid),
    .op_o         (op),
    .close_req_o  (close_req),
    .op_take_i    (op_take),
    .close_done_i (close_done)
  );

  vliw_dep_check #(.OP_W(OP_W), .REG_W(REG_W), .OPB(OPB), .IDX_W(IDX_W), .NPAIR(NPAIR)) u_dep (
    .wr_set_i   (wr_set),
    .op_i       (op),
    .wr_idx_o   (op_idx),
    .conflict_o (conflict)
  );

  vliw_open_group #(.SLOTS(SLOTS), .OPB(OPB), .IDX_W(IDX_W), .NPAIR(NPAIR)) u_grp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .op_i        (op),
    .op_idx_i    (op_idx),
    .cur_data_o  (cur_data),
    .cur_vld_o   (cur_vld),
    .fill_data_o (fill_data),
    .fill_vld_o  (fill_vld),
    .wr_set_o    (wr_set),
    .empty_o     (grp_empty),
    .last_slot_o (last_slot)
  );

  // close on last waits until the split has drained; close on conflict
  // restarts the group with the conflicting op in the same cycle
  always_comb begin
    act        = ACT_HOLD;
    op_take    = 1'b0;
    close_done = 1'b0;
    emit       = 1'b0;
    emit_fill  = 1'b0;
    if (close_req) begin
      if (grp_empty) begin
        close_done = 1'b1;
      end else if (out_free) begin
        act        = ACT_FLUSH;
        emit       = 1'b1;
        close_done = 1'b1;
      end
    end else if (op_valid) begin
      if (conflict) begin
        if (out_free) begin
          act     = ACT_SPLIT;
          emit    = 1'b1;
          op_take = 1'b1;
        end
      end else if (last_slot) begin
        if (out_free) begin
          act       = ACT_FILL;
          emit      = 1'b1;
          emit_fill = 1'b1;
          op_take   = 1'b1;
        end
      end else begin
        act     = ACT_APPEND;
        op_take = 1'b1;
      end
    end
  end

  assign emit_data = emit_fill ? fill_data : cur_data;
  assign emit_vld  = emit_fill ? fill_vld  : cur_vld;

  vliw_group_out #(.SLOTS(SLOTS), .OPB(OPB)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (emit),
    .data_i  (emit_data),
    .vld_i   (emit_vld),
    .ready_i (grp_ready_i),
    .valid_o (grp_valid_o),
    .data_o  (out_data),
    .vld_o   (slot_vld_o),
    .free_o  (out_free)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    logic [OPB-1:0] w;
    assign w = out_data[s*OPB +: OPB];
    assign slot_op_o[s*OP_W +: OP_W]    = w[4*REG_W+CH_W +: OP_W];
    assign slot_ch_o[s*2 +: 2]          = w[4*REG_W +: CH_W];
    assign slot_dst_o[s*REG_W +: REG_W]  = w[3*REG_W +: REG_W];
    assign slot_src0_o[s*REG_W +: REG_W] = w[2*REG_W +: REG_W];
    assign slot_src1_o[s*REG_W +: REG_W] = w[REG_W +: REG_W];
    assign slot_src2_o[s*REG_W +: REG_W] = w[0 +: REG_W];
  end
endmodule

// File: rtl/vliw_group_packer_chk.sv
module vliw_group_packer_chk #(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned REG_W = 2,
  parameter int unsigned SLOTS = 5
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic [3:0]             in_mask_i,
  input logic                   grp_valid_o,
  input logic                   grp_ready_i,
  input logic [SLOTS-1:0]       slot_vld_o,
  input logic [SLOTS*OP_W-1:0]  slot_op_o,
  input logic [SLOTS*2-1:0]     slot_ch_o,
  input logic [SLOTS*REG_W-1:0] slot_dst_o,
  input logic [SLOTS*REG_W-1:0] slot_src0_o,
  input logic [SLOTS*REG_W-1:0] slot_src1_o,
  input logic [SLOTS*REG_W-1:0] slot_src2_o
);
  logic [SLOTS-1:0] vld_inc;
  logic             raw_hit, waw_hit;

  assign vld_inc = slot_vld_o + 1'b1;

  always_comb begin
    raw_hit = 1'b0;
    waw_hit = 1'b0;
    for (int j = 1; j < SLOTS; j++) begin
      for (int i = 0; i < j; i++) begin
        if (slot_vld_o[i] && slot_vld_o[j] && slot_ch_o[i*2 +: 2] == slot_ch_o[j*2 +: 2]) begin
          if (slot_dst_o[i*REG_W +: REG_W] == slot_dst_o[j*REG_W +: REG_W]) waw_hit = 1'b1;
          if (slot_src0_o[j*REG_W +: REG_W] == slot_dst_o[i*REG_W +: REG_W] ||
              slot_src1_o[j*REG_W +: REG_W] == slot_dst_o[i*REG_W +: REG_W] ||
              slot_src2_o[j*REG_W +: REG_W] == slot_dst_o[i*REG_W +: REG_W]) raw_hit = 1'b1;
        end
      end
    end
  end

  AST_GRP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> slot_vld_o[0]); // R4
  AST_SLOT_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> ((slot_vld_o & vld_inc) == '0)); // R4
  AST_NO_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> !raw_hit); // R5
  AST_NO_WAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_valid_o |-> !waw_hit); // R6
  AST_SPLIT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && $countones(in_mask_i) > 1) |=> !in_ready_o); // R9
  AST_GRP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_valid_o && !grp_ready_i) |=> (grp_valid_o && $stable(slot_vld_o) && $stable(slot_op_o)
      && $stable(slot_ch_o) && $stable(slot_dst_o) && $stable(slot_src0_o)
      && $stable(slot_src1_o) && $stable(slot_src2_o))); // R10
  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!grp_valid_o && in_ready_o)); // R11
endmodule

bind vliw_group_packer vliw_group_packer_chk #(
  .OP_W(OP_W), .REG_W(REG_W), .SLOTS(SLOTS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_mask_i   (in_mask_i),
  .grp_valid_o (grp_valid_o),
  .grp_ready_i (grp_ready_i),
  .slot_vld_o  (slot_vld_o),
  .slot_op_o   (slot_op_o),
  .slot_ch_o   (slot_ch_o),
  .slot_dst_o  (slot_dst_o),
  .slot_src0_o (slot_src0_o),
  .slot_src1_o (slot_src1_o),
  .slot_src2_o (slot_src2_o)
);

// File: tb/vliw_group_packer_tb.sv
module vliw_group_packer_tb;
  localparam int OPB = 14;
  localparam int NT  = 12;
  // {last, op[3:0], dst, src0, src1, src2, mask[3:0]}
  localparam logic [16:0] TBL [NT] = '{
    {1'b0, 4'h1, 2'd0, 2'd1, 2'd2, 2'd3, 4'hF},  // 4 ops
    {1'b0, 4'h2, 2'd1, 2'd2, 2'd2, 2'd3, 4'h1},  // fifth op fills, R3
    {1'b0, 4'h3, 2'd2, 2'd1, 2'd1, 2'd1, 4'h3},
    {1'b0, 4'h4, 2'd3, 2'd2, 2'd0, 2'd0, 4'h1},  // reads r2.x, R5
    {1'b0, 4'h5, 2'd3, 2'd0, 2'd0, 2'd0, 4'h1},  // rewrites r3.x, R6
    {1'b0, 4'h6, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},  // zero mask, R2
    {1'b1, 4'h7, 2'd1, 2'd1, 2'd1, 2'd1, 4'hC},  // last, R8
    {1'b0, 4'h8, 2'd2, 2'd3, 2'd3, 2'd3, 4'h5},
    {1'b0, 4'h9, 2'd2, 2'd2, 2'd3, 2'd3, 4'h4},  // reads r2.z
    {1'b1, 4'hA, 2'd0, 2'd0, 2'd0, 2'd0, 4'hF},
    {1'b1, 4'hB, 2'd3, 2'd1, 2'd2, 2'd0, 4'h0},  // zero-mask last
    {1'b1, 4'hC, 2'd1, 2'd0, 2'd2, 2'd3, 4'hA}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_last_i = 1'b0;
  logic [3:0]  in_op_i = '0, in_mask_i = '0;
  logic [1:0]  in_dst_i = '0, in_src0_i = '0, in_src1_i = '0, in_src2_i = '0;
  logic        in_ready_o, grp_valid_o;
  logic        grp_ready_i = 1'b1;
  logic [4:0]  slot_vld_o;
  logic [19:0] slot_op_o;
  logic [9:0]  slot_ch_o, slot_dst_o, slot_src0_o, slot_src1_o, slot_src2_o;

  int tests = 0, fails = 0;
  int exp_n = 0, got_n = 0;
  logic [5*OPB-1:0] exp_data [256];
  logic [4:0]       exp_vld  [256];
  logic [OPB-1:0]   mg_slot  [5];
  int               mg_n = 0;
  logic [15:0]      mg_wr = '0;
  logic             bp_en = 1'b0;
  logic [7:0]       lfsr = 8'hA5;
  logic             prev_stall = 1'b0;
  logic [5*OPB-1:0] prev_data;
  logic [4:0]       prev_vld;

  always #2 clk_i = ~clk_i;

  vliw_group_packer u_dut (.*);

  always @(posedge clk_i) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    grp_ready_i <= bp_en ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [69:0] act, input logic [69:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5*OPB-1:0] got_group();
    logic [5*OPB-1:0] g = '0;
    for (int i = 0; i < 5; i++)
      if (slot_vld_o[i])
        g[i*OPB +: OPB] = {slot_op_o[i*4 +: 4], slot_ch_o[i*2 +: 2], slot_dst_o[i*2 +: 2],
                           slot_src0_o[i*2 +: 2], slot_src1_o[i*2 +: 2], slot_src2_o[i*2 +: 2]};
    return g;
  endfunction

  // reference packing, written from the requirements
  task automatic model_close();
    if (mg_n > 0) begin
      exp_data[exp_n] = '0;
      exp_vld[exp_n]  = '0;
      for (int i = 0; i < mg_n; i++) begin
        exp_data[exp_n][i*OPB +: OPB] = mg_slot[i];
        exp_vld[exp_n][i] = 1'b1;
      end
      exp_n++;
    end
    mg_n  = 0;
    mg_wr = '0;
  endtask

  task automatic model_op(input logic [OPB-1:0] o);
    logic [1:0] ch = o[9:8];
    bit hit = mg_wr[{o[7:6], ch}] || mg_wr[{o[5:4], ch}] || mg_wr[{o[3:2], ch}] || mg_wr[{o[1:0], ch}];
    if (hit) model_close();
    mg_slot[mg_n] = o;
    mg_n++;
    mg_wr[{o[7:6], ch}] = 1'b1;
    if (mg_n == 5) model_close();
  endtask

  task automatic model_instr(input logic [16:0] ins);
    for (int c = 0; c < 4; c++)
      if (ins[c]) model_op({ins[15:12], 2'(c), ins[11:4]});
    if (ins[16]) model_close();
  endtask

  task automatic send(input logic [16:0] ins);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    {in_last_i, in_op_i, in_dst_i, in_src0_i, in_src1_i, in_src2_i, in_mask_i} = ins;
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    model_instr(ins);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (got_n != exp_n || grp_valid_o || !in_ready_o) @(negedge clk_i);
  endtask

  // monitor: group content, order and hold under backpressure
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall)
        chk(got_group() == prev_data && slot_vld_o == prev_vld && grp_valid_o,
            "R10 hold", {slot_vld_o, got_group()}, {prev_vld, prev_data});
      prev_stall = grp_valid_o && !grp_ready_i;
      prev_data  = got_group();
      prev_vld   = slot_vld_o;
      if (grp_valid_o && grp_ready_i) begin
        if (got_n < exp_n)
          chk(slot_vld_o == exp_vld[got_n] && got_group() == exp_data[got_n],
              "R1 R2 R3 R5 R6 R7 R8 group", {slot_vld_o, got_group()},
              {exp_vld[got_n], exp_data[got_n]});
        else
          chk(1'b0, "R8 unexpected group", {slot_vld_o, got_group()}, '0);
        got_n++;
      end
    end else begin
      prev_stall = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o && !grp_valid_o, "R11 reset state", {68'b0, in_ready_o, grp_valid_o}, 70'b10);

    // R1 R7: mask 1010 -> channels 1 then 3, then close on last
    send({1'b1, 4'h9, 2'd1, 2'd2, 2'd3, 2'd0, 4'b1010});
    while (!grp_valid_o) @(negedge clk_i);
    chk(slot_vld_o == 5'b00011, "R1 slot count", 70'(slot_vld_o), 70'b00011);
    chk(slot_ch_o[3:0] == 4'b1101 && slot_op_o[7:0] == 8'h99 && slot_dst_o[3:0] == 4'b0101,
        "R7 channel order", {slot_ch_o[3:0], slot_op_o[7:0], slot_dst_o[3:0]}, {4'b1101, 8'h99, 4'b0101});
    wait_idle();

    // R9: full-mask instruction stalls the input while split
    send({1'b0, 4'h1, 2'd0, 2'd1, 2'd2, 2'd3, 4'hF});
    chk(!in_ready_o, "R9 ready low while pending", 70'(in_ready_o), 70'd0);
    send({1'b1, 4'h2, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0});
    wait_idle();

    for (int p = 0; p < 2; p++) begin
      bp_en = (p == 1);
      for (int t = 0; t < NT; t++) send(TBL[t]);
      wait_idle();
    end
    bp_en = 1'b0;
    repeat (2) @(negedge clk_i);

    // R8 / R11: open group without last is not sent; reset discards it
    send({1'b0, 4'h3, 2'd2, 2'd0, 2'd0, 2'd0, 4'h3});
    repeat (6) @(negedge clk_i);
    chk(!grp_valid_o, "R8 no close without last", 70'(grp_valid_o), 70'd0);
    rst_ni = 1'b0;
    mg_n = 0;
    mg_wr = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    send({1'b1, 4'hE, 2'd3, 2'd1, 2'd1, 2'd1, 4'h2});
    while (!grp_valid_o) @(negedge clk_i);
    chk(slot_vld_o == 5'b00001 && slot_op_o[3:0] == 4'hE && slot_ch_o[1:0] == 2'd1,
        "R11 reset clears open group", {slot_vld_o, slot_op_o[3:0], slot_ch_o[1:0]},
        {5'b00001, 4'hE, 2'd1});
    wait_idle();
    chk(got_n == exp_n, "R8 group count", 70'(got_n), 70'(exp_n));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule